// File: doc/BRIEF.md
# Multi-Client Liveness Quorum for Watchdog Refresh

This block sits between a set of independent clients (software tasks, hardware engines, subsystems) and a downstream watchdog. Each client pulses its own heartbeat input whenever it completes a cycle of useful work. The block latches each pulse in a per-client alive flag. It forwards a single refresh strobe to the watchdog only once every mandatory client has checked in since the previous refresh. The refresh and the clearing of every flag happen on the same clock edge, so each round starts empty.

Because the refresh waits for the AND of all enabled flags, a fast client that beats many times cannot keep the watchdog fed on its own. The slowest mandatory client sets the gap between refreshes, and a silent client stops refreshes altogether. A per-client enable mask lets unused client slots be left out of the quorum. An all-zero mask never produces a refresh, so a block left unconfigured lets the watchdog expire instead of hiding the mistake. The current flag vector is brought out for debug.

Top module: `hb_quorum_top`

## Requirements
- R1: While the synchronous active-high reset is asserted, and in the cycle after it, `alive_o` is all zeros and `refresh_o` is 0.
- R2: A heartbeat on an enabled client `i` (bit `i` of `beat_i` high at a rising edge) sets bit `i` of `alive_o` after that edge and touches no other bit.
- R3: When every enabled bit of `alive_o` is 1, the mask is not all zeros and no refresh is in progress, `refresh_o` is 1 after the next rising edge.
- R4: All alive flags clear on the same edge on which `refresh_o` rises.
- R5: A heartbeat presented during the cycle in which the flags clear is kept. Its bit reads 1 after that edge and counts toward the next round.
- R6: A client whose `en_mask_i` bit is 0 counts as alive for the quorum. Its `alive_o` bit reads 0, both when it beats while disabled and after it is disabled with its flag set.
- R7: While `en_mask_i` is all zeros, `refresh_o` never rises.
- R8: Any number of repeated heartbeats from some clients produces no refresh while one enabled client stays silent.
- R9: `refresh_o` is a registered pulse one cycle wide and is never high on two consecutive cycles. A quorum that is met again during the refresh cycle produces its refresh one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| beat_i | input | N_CLIENTS | One heartbeat strobe per client, sampled on every rising edge |
| en_mask_i | input | N_CLIENTS | 1 = client belongs to the quorum, 0 = ignored |
| refresh_o | output | 1 | One-cycle refresh strobe toward the watchdog |
| alive_o | output | N_CLIENTS | Current alive flags, for debug |

## Verification
The embedded assertions check the cycle-local rules on every clock. They check that a flag only rises after its own heartbeat, that a refresh follows a met quorum, that nothing survives a refresh except the beats of that cycle, that the refresh pulse stays one cycle wide and that an empty mask yields nothing. The ordering behaviour needs the bench's scenarios. Only a stimulus sequence can show that a persistently silent client holds off refreshes over many cycles, that a round started during a clear completes one cycle late, and that changing the mask mid-round changes when the quorum is met.

// File: rtl/hb_pkg.sv
package hb_pkg;

  // Phase of the refresh output register.
  typedef enum logic {
    HB_COLLECT = 1'b0,
    HB_FIRE    = 1'b1
  } hb_phase_e;

  // Default number of client slots.
  localparam int unsigned HB_DEFAULT_CLIENTS = 4;

endpackage

// File: rtl/hb_alive_cell.sv
// One alive flag. It is set by its own heartbeat, dropped when the client is
// disabled, and reloaded with the current beat on a quorum clear.
module hb_alive_cell (
  input  logic clk,
  input  logic rst,
  input  logic beat,
  input  logic enable,
  input  logic clear,
  output logic alive
);

  logic alive_q;
  logic alive_d;

  always_comb begin
    if (clear) alive_d = beat & enable;            // R5: same-cycle beat kept
    else       alive_d = (alive_q | beat) & enable; // R2 / R6
  end

  always_ff @(posedge clk) begin
    if (rst) alive_q <= 1'b0;
    else     alive_q <= alive_d;
  end

  assign alive = alive_q;

  // R2: a flag can only rise after its own heartbeat
  a_r2_rise_needs_beat: assert property (@(posedge clk) disable iff (rst)
    $rose(alive_q) |-> $past(beat));

  // R6: a disabled client never shows a set flag on the next cycle
  a_r6_disabled_low: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !alive_q);

endmodule

// File: rtl/hb_alive_bank.sv
// Bank of per-client alive flags.
module hb_alive_bank #(
  parameter int unsigned N_CLIENTS = hb_pkg::HB_DEFAULT_CLIENTS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_CLIENTS-1:0] beat,
  input  logic [N_CLIENTS-1:0] enable,
  input  logic                 clear,
  output logic [N_CLIENTS-1:0] alive
);

  for (genvar g = 0; g < N_CLIENTS; g++) begin : g_cell
    hb_alive_cell u_cell (
      .clk    (clk),
      .rst    (rst),
      .beat   (beat[g]),
      .enable (enable[g]),
      .clear  (clear),
      .alive  (alive[g])
    );
  end

endmodule

// File: rtl/hb_quorum_eval.sv
// Decides whether every mandatory client has reported. A disabled slot counts
// as satisfied. An empty mask never forms a quorum.
module hb_quorum_eval #(
  parameter int unsigned N_CLIENTS = hb_pkg::HB_DEFAULT_CLIENTS
) (
  input  logic [N_CLIENTS-1:0] alive,
  input  logic [N_CLIENTS-1:0] enable,
  output logic                 met
);

  logic [N_CLIENTS-1:0] slot_ok;

  for (genvar g = 0; g < N_CLIENTS; g++) begin : g_slot
    assign slot_ok[g] = alive[g] | ~enable[g];
  end

  assign met = (|enable) & (&slot_ok);

endmodule

// File: rtl/hb_quorum_top.sv
module hb_quorum_top #(
  parameter int unsigned N_CLIENTS = hb_pkg::HB_DEFAULT_CLIENTS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_CLIENTS-1:0] beat_i,
  input  logic [N_CLIENTS-1:0] en_mask_i,
  output logic                 refresh_o,
  output logic [N_CLIENTS-1:0] alive_o
);

  import hb_pkg::*;

  hb_phase_e            phase_q;
  logic                 quorum_met;
  logic                 fire;
  logic [N_CLIENTS-1:0] alive_vec;

  hb_alive_bank #(.N_CLIENTS(N_CLIENTS)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .beat   (beat_i),
    .enable (en_mask_i),
    .clear  (fire),
    .alive  (alive_vec)
  );

  hb_quorum_eval #(.N_CLIENTS(N_CLIENTS)) u_eval (
    .alive  (alive_vec),
    .enable (en_mask_i),
    .met    (quorum_met)
  );

  // R9: no new refresh while the previous one is still on the output
  assign fire = quorum_met & (phase_q == HB_COLLECT);

  always_ff @(posedge clk) begin
    if (rst)       phase_q <= HB_COLLECT;
    else if (fire) phase_q <= HB_FIRE;
    else           phase_q <= HB_COLLECT;
  end

  assign refresh_o = (phase_q == HB_FIRE);
  assign alive_o   = alive_vec;

  // R3: a refresh only follows a cycle with a complete, non-empty quorum
  a_r3_refresh_after_quorum: assert property (@(posedge clk) disable iff (rst)
    refresh_o |-> $past((|en_mask_i) && ((alive_o | ~en_mask_i) == '1)));

  // R4 / R5: after a refresh only the beats of the clear cycle may remain
  a_r4_cleared_on_refresh: assert property (@(posedge clk) disable iff (rst)
    refresh_o |-> ((alive_o & ~$past(beat_i)) == '0));

  // R7: empty mask never produces a refresh
  a_r7_empty_mask_quiet: assert property (@(posedge clk) disable iff (rst)
    (en_mask_i == '0) |=> !refresh_o);

  // R9: pulse is one cycle wide
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    refresh_o |=> !refresh_o);

endmodule

// File: tb/sim_hb_quorum_top.sv
`timescale 1ns/1ps
module sim_hb_quorum_top;

  localparam int N = 4;
  localparam int NV = 29;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] beat = '0;
  logic [N-1:0] mask = '0;
  logic         refresh;
  logic [N-1:0] alive;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  hb_quorum_top #(.N_CLIENTS(N)) u0 (
    .clk       (clk),
    .rst       (rst),
    .beat_i    (beat),
    .en_mask_i (mask),
    .refresh_o (refresh),
    .alive_o   (alive)
  );

  // {mask, beat, expected alive, expected refresh}, one clock each
  localparam logic [12:0] VEC [NV] = '{
    13'b1111_0001_0001_0, // R2
    13'b1111_0001_0001_0, // R8 repeat from fast client
    13'b1111_0100_0101_0,
    13'b1111_0010_0111_0,
    13'b1111_0001_0111_0, // R8
    13'b1111_1000_1111_0, // R2 last client in
    13'b1111_0000_0000_1, // R3 R4
    13'b1111_0000_0000_0, // R9
    13'b1111_1111_1111_0,
    13'b1111_0011_0011_1, // R5 beats kept on clear
    13'b1111_1100_1111_0,
    13'b1111_0000_0000_1, // R3
    13'b1111_0000_0000_0,
    13'b1111_1111_1111_0,
    13'b1111_1111_1111_1, // R5 full round during clear
    13'b1111_0000_1111_0, // R9 deferred
    13'b1111_0000_0000_1, // R9 one cycle later
    13'b1111_0000_0000_0,
    13'b0101_1010_0000_0, // R6 disabled beats ignored
    13'b0101_0001_0001_0,
    13'b0101_0100_0101_0,
    13'b0101_0000_0000_1, // R6 disabled count as alive
    13'b0101_0000_0000_0,
    13'b0000_1111_0000_0, // R7
    13'b0000_0000_0000_0, // R7
    13'b0000_0000_0000_0, // R7
    13'b1111_0011_0011_0,
    13'b0011_0000_0000_1, // R6 mask shrink completes quorum
    13'b0011_0000_0000_0
  };

  task automatic check(input string req, input logic [N-1:0] exp_alive,
                       input logic exp_ref);
    checks++;
    if (alive !== exp_alive || refresh !== exp_ref) begin
      errors++;
      $display("FAIL %s: alive=%b refresh=%b expected alive=%b refresh=%b",
               req, alive, refresh, exp_alive, exp_ref);
    end
  endtask

  task automatic step(input logic [N-1:0] m, input logic [N-1:0] b);
    @(negedge clk);
    mask = m;
    beat = b;
    @(posedge clk);
    #2;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    rst = 1'b1;
    step('0, '0);
    step(4'b1111, 4'b1111);
    check("R1", 4'b0000, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    beat = '0;
    @(posedge clk);
    #2;
    check("R1", 4'b0000, 1'b0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][12:9], VEC[i][8:5]);
      check($sformatf("vec%0d", i), VEC[i][4:1], VEC[i][0]);
    end

    // R8: client 3 silent, others beat for many cycles
    for (int c = 0; c < 40; c++) begin
      step(4'b1111, 4'b0111);
      if (c % 8 == 0) check("R8", 4'b0111, 1'b0);
    end
    step(4'b1111, 4'b1000);
    check("R8", 4'b1111, 1'b0);
    step(4'b1111, 4'b0000);
    check("R3", 4'b0000, 1'b1);

    // R1: reset mid-round clears flags
    step(4'b1111, 4'b0110);
    check("R2", 4'b0110, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    beat = '0;
    @(posedge clk);
    #2;
    check("R1", 4'b0000, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    // R2: single enabled client quorum
    step(4'b0010, 4'b0010);
    check("R2", 4'b0010, 1'b0);
    step(4'b0010, 4'b0000);
    check("R3", 4'b0000, 1'b1);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule